// File: doc/BRIEF.md
# Pattern-Expanding RAM Address Sequencer

This block drives the read and write addresses of a set of data RAMs from a short program of pattern instructions. It does not store one control word per cycle. Each stored instruction names an access pattern and the pattern's geometry, and the block expands it into one address per cycle. The operation select of the instruction is emitted with every address. Three patterns are supported:
- a linear run of consecutive addresses;
- a row-order walk of a matrix, for the standard matrix-vector product;
- a column-order walk of the same matrix, for the transposed product.

A pulse on `start` runs the program from instruction 0 to a programmable last index. After the last instruction the block wraps back to instruction 0 and replays the whole program for the next independent problem. On each replay a problem offset is added to every address: the problem index times a programmable region size. When the last problem's final instruction has emitted its final address, `done` pulses and the block goes idle. Arithmetic datapaths are outside this block.

Top module: `pattern_addr_seq`

## Requirements
- R1: While reset is asserted, and from reset until the first `start`, `addr_o`, `op_o`, `prob_o`, `vld_o` and `done_o` are all 0. A reset applied in the middle of a run returns the block to this idle state.
- R2: The instruction word is `{kind[1:0], op[2:0], base[11:0], inner_m1[5:0], outer_m1[5:0], stride[11:0]}`, with kind in bits 40:39 and stride in bits 11:0. Kind 0 and kind 3 are linear runs. A linear run emits base+off+i for i = 0..inner_m1, one per cycle with `vld_o` high, and ignores outer_m1 and stride.
- R3: Kind 1 is a row walk. It emits base+off+o*stride+i, with o = 0..outer_m1 as the slow index and i = 0..inner_m1 as the fast index.
- R4: Kind 2 is a column walk. It emits base+off+i*stride+o, with o = 0..outer_m1 as the slow index and i = 0..inner_m1 as the fast index.
- R5: After instruction `last_idx` completes, the sequencer returns to instruction 0 and `prob_o` increments. Problems 0..`last_prob` are run in turn. Problem p uses off = p*`region`.
- R6: `done_o` is high for exactly one cycle: the cycle right after the final address of the last problem. `vld_o` is low from that cycle on.
- R7: The first address appears in the cycle after the clock edge that samples `start`. Each instruction's first address follows the previous instruction's last address in the very next cycle, with no idle cycle between them.
- R8: `op_o` carries the op field of the instruction that produced the current address, for every address of that instruction.
- R9: While a run is in progress, `start` pulses are ignored, and load-port writes (`ld_en`) do not change the stored program.
- R10: Address arithmetic wraps modulo 2^12, so a run that passes 4095 continues from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write `ld_word` into program slot `ld_idx` (idle only) |
| ld_idx | input | 3 | Program slot to write |
| ld_word | input | 41 | Instruction word |
| last_idx | input | 3 | Index of the last instruction in the program |
| last_prob | input | 3 | Index of the last problem |
| region | input | 12 | Address region size per problem |
| start | input | 1 | Begin a run (pulse) |
| addr_o | output | 12 | Generated address |
| vld_o | output | 1 | Address is valid this cycle |
| op_o | output | 3 | Operation select of the current instruction |
| prob_o | output | 3 | Index of the problem being served |
| done_o | output | 1 | One-cycle pulse after the final address |

## Verification
The bench aims at the boundaries where the nested counters turn over:
- A design that confuses the row and column walks would swap the stride between the fast and slow index.
- A design that spends a cycle on instruction fetch would leave a hole between instructions.
- A design that forgets to advance the problem offset would replay every problem on the same addresses.

Further directed tests target the following:
- A kind-3 word treated as a matrix walk, which would emit too many addresses.
- An address run across 4095, where a design that saturates instead of wrapping would stick at the top.
- A start pulse and a program write landing mid-run: a design that honours them would restart, or would replay a corrupted instruction for the second problem.

// File: rtl/pattern_addr_seq.sv
module pattern_addr_seq #(
  parameter int AW    = 12,
  parameter int LW    = 6,
  parameter int OPW   = 3,
  parameter int DEPTH = 8,
  parameter int PBW   = 3,
  localparam int PCW  = $clog2(DEPTH),
  localparam int IW   = 2 + OPW + 2*AW + 2*LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [PCW-1:0] ld_idx,
  input  logic [IW-1:0]  ld_word,
  input  logic [PCW-1:0] last_idx,
  input  logic [PBW-1:0] last_prob,
  input  logic [AW-1:0]  region,
  input  logic           start,
  output logic [AW-1:0]  addr_o,
  output logic           vld_o,
  output logic [OPW-1:0] op_o,
  output logic [PBW-1:0] prob_o,
  output logic           done_o
);

  logic [IW-1:0]  prog [DEPTH];
  logic           run;
  logic [PCW-1:0] pc;
  logic [LW-1:0]  inner, outer;
  logic [AW-1:0]  iacc, oacc, poff;
  logic [PBW-1:0] prob;
  logic           done_q;

  logic [IW-1:0]  cur;
  logic [1:0]     kind;
  logic [OPW-1:0] op;
  logic [AW-1:0]  base, stride, istep, ostep;
  logic [LW-1:0]  inner_m1, outer_m1;
  logic           two_d, col, line_end, pat_end;

  assign cur      = prog[pc];
  assign stride   = cur[AW-1:0];
  assign outer_m1 = cur[AW +: LW];
  assign inner_m1 = cur[AW+LW +: LW];
  assign base     = cur[AW+2*LW +: AW];
  assign op       = cur[2*AW+2*LW +: OPW];
  assign kind     = cur[IW-1 -: 2];

  assign two_d    = (kind == 2'd1) || (kind == 2'd2);
  assign col      = (kind == 2'd2);
  assign istep    = col ? stride : AW'(1);
  assign ostep    = col ? AW'(1) : stride;
  assign line_end = (inner == inner_m1);
  assign pat_end  = line_end && (!two_d || outer == outer_m1);

  assign vld_o  = run;
  assign addr_o = run ? base + poff + iacc + oacc : '0;
  assign op_o   = run ? op : '0;
  assign prob_o = prob;
  assign done_o = done_q;

  always_ff @(posedge clk)
    if (ld_en && !run) prog[ld_idx] <= ld_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      pc     <= '0;
      inner  <= '0;
      outer  <= '0;
      iacc   <= '0;
      oacc   <= '0;
      prob   <= '0;
      poff   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          run   <= 1'b1;
          pc    <= '0;
          inner <= '0;
          outer <= '0;
          iacc  <= '0;
          oacc  <= '0;
          prob  <= '0;
          poff  <= '0;
        end
      end else if (!line_end) begin
        inner <= inner + LW'(1);
        iacc  <= iacc + istep;
      end else if (!pat_end) begin
        inner <= '0;
        iacc  <= '0;
        outer <= outer + LW'(1);
        oacc  <= oacc + ostep;
      end else begin
        inner <= '0;
        outer <= '0;
        iacc  <= '0;
        oacc  <= '0;
        if (pc != last_idx) begin
          pc <= pc + PCW'(1);
        end else begin
          pc <= '0;
          if (prob != last_prob) begin
            prob <= prob + PBW'(1);
            poff <= poff + region;
          end else begin
            run    <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  p_inner_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && inner != '0) |-> (addr_o == $past(addr_o) + (col ? stride : AW'(1))))
    else $error("inner step broken");

  p_prob_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(vld_o)) |-> (prob_o == $past(prob_o) || prob_o == $past(prob_o) + PBW'(1)))
    else $error("problem index jumped");

  p_pc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (pc <= last_idx))
    else $error("pc beyond last instruction");

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(vld_o) && !vld_o))
    else $error("done without preceding address");

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

endmodule

// File: tb/tb_pattern_addr_seq.sv
`timescale 1ns/1ps
module tb_pattern_addr_seq;
  logic        clk = 0, rst_n = 0;
  logic        ld_en = 0, start = 0;
  logic [2:0]  ld_idx = 0, last_idx = 0, last_prob = 0;
  logic [40:0] ld_word = 0;
  logic [11:0] region = 0;
  logic [11:0] addr_o;
  logic        vld_o, done_o;
  logic [2:0]  op_o, prob_o;

  pattern_addr_seq dut (.clk, .rst_n, .ld_en, .ld_idx, .ld_word, .last_idx,
    .last_prob, .region, .start, .addr_o, .vld_o, .op_o, .prob_o, .done_o);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int n_exp;
  int e_addr [1024];
  int e_op   [1024];
  int e_prob [1024];
  int q_kind [8], q_op [8], q_base [8], q_da [8], q_db [8], q_st [8];

  localparam int NT = 6;
  localparam int T_KIND [NT] = '{0, 1, 2, 3, 0, 2};
  localparam int T_BASE [NT] = '{10, 100, 200, 50, 4090, 0};
  localparam int T_DA   [NT] = '{4, 2, 2, 3, 9, 1};
  localparam int T_DB   [NT] = '{0, 1, 3, 5, 0, 1};
  localparam int T_ST   [NT] = '{0, 8, 4, 7, 0, 16};
  localparam int T_REG  [NT] = '{0, 0, 0, 0, 0, 300};
  localparam int T_LP   [NT] = '{0, 0, 0, 0, 0, 2};
  localparam int T_OP   [NT] = '{1, 2, 3, 4, 5, 6};

  function automatic logic [40:0] enc(int k, int o, int b, int da, int db, int st);
    return {k[1:0], o[2:0], b[11:0], da[5:0], db[5:0], st[11:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(int idx, int k, int o, int b, int da, int db, int st);
    @(negedge clk);
    ld_en = 1; ld_idx = idx[2:0]; ld_word = enc(k, o, b, da, db, st);
    q_kind[idx] = k; q_op[idx] = o; q_base[idx] = b; q_da[idx] = da; q_db[idx] = db; q_st[idx] = st;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic build(int li, int lp, int rg);
    n_exp = 0;
    for (int p = 0; p <= lp; p++)
      for (int pc = 0; pc <= li; pc++) begin
        int outs;
        outs = (q_kind[pc] == 1 || q_kind[pc] == 2) ? q_db[pc] : 0;
        for (int o = 0; o <= outs; o++)
          for (int i = 0; i <= q_da[pc]; i++) begin
            int a;
            if (q_kind[pc] == 2) a = q_base[pc] + p*rg + i*q_st[pc] + o;
            else                 a = q_base[pc] + p*rg + o*q_st[pc] + i;
            e_addr[n_exp] = a & 12'hFFF;
            e_op[n_exp]   = q_op[pc];
            e_prob[n_exp] = p;
            n_exp++;
          end
      end
  endtask

  task automatic run_seq(string req, int poke_at);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < n_exp; k++) begin
      int act, exp;
      if (k == poke_at) begin
        start = 1; ld_en = 1; ld_idx = 0; ld_word = enc(1, 7, 3000, 5, 5, 1);
      end
      act = {vld_o, prob_o, op_o, addr_o};
      exp = {1'b1, e_prob[k][2:0], e_op[k][2:0], e_addr[k][11:0]};
      chk(act == exp, req, act, exp);
      @(negedge clk);
      if (k == poke_at) begin start = 0; ld_en = 0; end
    end
    chk(done_o == 1 && vld_o == 0, "R6 done after last", {done_o, vld_o}, 2);
    @(negedge clk);
    chk(done_o == 0 && vld_o == 0, "R6 done one cycle", {done_o, vld_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({addr_o, op_o, prob_o, vld_o, done_o} == 0, "R1 reset idle",
        {addr_o, op_o, prob_o, vld_o, done_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({addr_o, op_o, prob_o, vld_o, done_o} == 0, "R1 idle after reset",
        {addr_o, op_o, prob_o, vld_o, done_o}, 0);

    // table of single-instruction programs: R2 R3 R4 R5 R10
    for (int t = 0; t < NT; t++) begin
      load(0, T_KIND[t], T_OP[t], T_BASE[t], T_DA[t], T_DB[t], T_ST[t]);
      last_idx = 0; last_prob = T_LP[t][2:0]; region = T_REG[t][11:0];
      build(0, T_LP[t], T_REG[t]);
      case (t)
        0: run_seq("R2 linear run", -1);
        1: run_seq("R3 row walk", -1);
        2: run_seq("R4 column walk", -1);
        3: run_seq("R2 kind3 linear", -1);
        4: run_seq("R10 address wrap", -1);
        default: run_seq("R5 replay offset", -1);
      endcase
    end

    // multi-instruction program, back-to-back: R7 R8 R5
    load(0, 0, 1, 5, 2, 0, 0);
    load(1, 1, 2, 40, 1, 1, 10);
    load(2, 2, 7, 80, 1, 2, 3);
    last_idx = 2; last_prob = 1; region = 1000;
    build(2, 1, 1000);
    run_seq("R7 R8 no-gap program", -1);

    // start and load mid-run must be ignored: R9
    run_seq("R9 mid-run start/load ignored", 5);
    build(2, 1, 1000);
    run_seq("R9 program intact after run", -1);

    // reset in the middle of a run: R1
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk({addr_o, op_o, prob_o, vld_o, done_o} == 0, "R1 reset mid-run",
        {addr_o, op_o, prob_o, vld_o, done_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(vld_o == 0, "R1 stays idle", vld_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule